// File: doc/BRIEF.md
# Dual-Width Timer with Output Compare

This block is a timer/counter peripheral that sits behind a byte-wide register port. It counts timer ticks either as an 8-bit counter held in the low counter byte or, when the width bit is set, as one 16-bit counter that spans a low and a high byte. Two output compare channels watch the count. Each channel raises a sticky interrupt flag when it matches, and software clears a flag by writing a one to it.

In 16-bit mode the CPU still moves one byte per access. A single 8-bit staging register is shared by all 16-bit registers, so that both halves of a value move in the same cycle. A high-byte write is parked in the staging register and lands together with the next low-byte write. A low-byte read of the counter snapshots the high byte into the staging register, and a later high-byte read returns that snapshot.

After a CPU write to the counter low byte, the next tick that advances the counter cannot raise a compare flag. This prevents a spurious match on a value that software has just loaded. The register port is a single-cycle register access with no back-pressure: a read returns data combinationally in the cycle `rd_en` is high, and a write takes effect at the clock edge that ends its cycle. `tick` and `count_en` are plain level controls that are sampled on each clock edge.

Top module: `dmt_top`

## Requirements
- R1: After reset, every register reads zero at its address: 0 control, 1 counter low, 2 counter high, 3 compare A low, 4 compare A high, 5 compare B, 6 flags. The flags register has bit 0 for compare A and bit 1 for compare B. The control register has bit 0 set for 16-bit mode.
- R2: In 8-bit mode, each clock edge with `tick` and `count_en` both high adds one to the counter low byte, which wraps from 255 to 0. The counter high byte is left unchanged. Without both signals high, the counter holds its value.
- R3: In 16-bit mode, each advancing edge adds one to the full 16-bit counter. The carry passes into the high byte, and the counter wraps from 65535 to 0.
- R4: A CPU write to a counter register in the same cycle as a tick loads the written value, and no increment is applied in that cycle.
- R5: In 16-bit mode, a write to address 2 or 4 loads only the staging register. A following write to address 1 or 3 loads {staging, write data} into the counter or compare A in one cycle.
- R6: In 16-bit mode, a read of address 1 returns the counter low byte and copies the counter high byte into the staging register. A read of address 2 returns the staging register.
- R7: Compare A sets flag bit 0 on an advancing tick whose pre-tick count equals the compare value. In 8-bit mode only the low bytes are compared. In 16-bit mode all 16 bits of the count are compared with {compare A high, compare A low}.
- R8: Compare B sets flag bit 1 on an advancing tick whose pre-tick count byte equals compare B. That byte is the counter low byte in 8-bit mode and the counter high byte in 16-bit mode.
- R9: After a CPU write to the counter low byte, the next advancing tick sets no compare flag, even when the count matches. Later ticks compare normally.
- R10: A flag stays set until a write to address 6 with a one in the flag's bit position, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick, one count per clock edge while high |
| count_en | input | 1 | Count enable, qualifies `tick` |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| irq_a | output | 1 | Compare A interrupt flag |
| irq_b | output | 1 | Compare B interrupt flag |

## Verification
The tests run in 8-bit mode and in 16-bit mode. In 8-bit mode, runs of ticks pass the compare A and compare B values, a run is repeated with the enable low, and a run crosses 255 to 0, which separates a wrap from a carry into the high byte. In 16-bit mode, the counter is loaded just below 65535. Compare A is tried with a count whose low byte matches but whose high byte differs, and again with a count that matches in full. Compare B is tried with a high byte that matches, which tells the two byte selections apart. The counter is also loaded onto a matching value with no run-up, and again one below it, which shows whether the blocked tick is exactly one and not more.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL    = 3'd0,
    RA_CNT_LO  = 3'd1,
    RA_CNT_HI  = 3'd2,
    RA_CMPA_LO = 3'd3,
    RA_CMPA_HI = 3'd4,
    RA_CMPB    = 3'd5,
    RA_FLAGS   = 3'd6
  } reg_addr_e;

  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;
endpackage

// File: rtl/dmt_bus.sv
module dmt_bus
  import dmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [W-1:0]        wdata,
  input  logic [2*W-1:0]      cnt_q,
  input  logic [NUM_CH-1:0]   flags,
  output logic [W-1:0]        rdata,
  output logic                wide,
  output logic                cnt_ld,
  output logic                cnt_lo_wr,
  output logic [2*W-1:0]      cnt_ld_val,
  output logic [2*W-1:0]      cmpa,
  output logic [W-1:0]        cmpb,
  output logic [NUM_CH-1:0]   flag_clr
);
  localparam int DW = 2 * W;

  logic [W-1:0] stage_q;
  logic         wide_q;
  logic [DW-1:0] cmpa_q;
  logic [W-1:0]  cmpb_q;

  logic [W-1:0] cnt_lo, cnt_hi;
  assign cnt_lo = cnt_q[W-1:0];
  assign cnt_hi = cnt_q[DW-1:W];

  logic wr_ctrl, wr_clo, wr_chi, wr_alo, wr_ahi, wr_b, wr_flg, rd_clo;
  assign wr_ctrl = wr_en && (addr == RA_CTRL);
  assign wr_clo  = wr_en && (addr == RA_CNT_LO);
  assign wr_chi  = wr_en && (addr == RA_CNT_HI);
  assign wr_alo  = wr_en && (addr == RA_CMPA_LO);
  assign wr_ahi  = wr_en && (addr == RA_CMPA_HI);
  assign wr_b    = wr_en && (addr == RA_CMPB);
  assign wr_flg  = wr_en && (addr == RA_FLAGS);
  assign rd_clo  = rd_en && (addr == RA_CNT_LO);

  // Counter load request toward the counter
  always_comb begin
    cnt_ld     = 1'b0;
    cnt_ld_val = cnt_q;
    if (wr_clo) begin
      cnt_ld     = 1'b1;
      cnt_ld_val = wide_q ? {stage_q, wdata} : {cnt_hi, wdata};
    end else if (wr_chi && !wide_q) begin
      cnt_ld     = 1'b1;
      cnt_ld_val = {wdata, cnt_lo};
    end
  end
  assign cnt_lo_wr = wr_clo;

  // Staging byte shared by all 16-bit registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (wide_q && (wr_chi || wr_ahi)) begin
      stage_q <= wdata;
    end else if (wide_q && rd_clo) begin
      stage_q <= cnt_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (wr_ctrl) wide_q <= wdata[0];
      if (wr_alo) begin
        if (wide_q) cmpa_q <= {stage_q, wdata};
        else        cmpa_q[W-1:0] <= wdata;
      end else if (wr_ahi && !wide_q) begin
        cmpa_q[DW-1:W] <= wdata;
      end
      if (wr_b) cmpb_q <= wdata;
    end
  end

  assign flag_clr = wr_flg ? wdata[NUM_CH-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        RA_CTRL:    rdata = {{(W-1){1'b0}}, wide_q};
        RA_CNT_LO:  rdata = cnt_lo;
        RA_CNT_HI:  rdata = wide_q ? stage_q : cnt_hi;
        RA_CMPA_LO: rdata = cmpa_q[W-1:0];
        RA_CMPA_HI: rdata = cmpa_q[DW-1:W];
        RA_CMPB:    rdata = cmpb_q;
        RA_FLAGS:   rdata = {{(W-NUM_CH){1'b0}}, flags};
        default:    rdata = '0;
      endcase
    end
  end

  assign wide = wide_q;
  assign cmpa = cmpa_q;
  assign cmpb = cmpb_q;
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           count_en,
  input  logic           wide,
  input  logic           ld,
  input  logic [2*W-1:0] ld_val,
  output logic [2*W-1:0] cnt_q,
  output logic           step
);
  localparam int DW = 2 * W;

  logic [DW-1:0] cnt_r, cnt_inc;

  // A CPU load wins over the tick
  assign step = tick && count_en && !ld;

  always_comb begin
    if (wide) cnt_inc = cnt_r + 1'b1;
    else      cnt_inc = {cnt_r[DW-1:W], W'(cnt_r[W-1:0] + 1'b1)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_r <= '0;
    else if (ld)   cnt_r <= ld_val;
    else if (step) cnt_r <= cnt_inc;
  end

  assign cnt_q = cnt_r;
endmodule

// File: rtl/dmt_match.sv
module dmt_match
  import dmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              cnt_lo_wr,
  input  logic              wide,
  input  logic [2*W-1:0]    cnt_q,
  input  logic [2*W-1:0]    cmpa,
  input  logic [W-1:0]      cmpb,
  input  logic [NUM_CH-1:0] flag_clr,
  output logic [NUM_CH-1:0] flags
);
  localparam int DW = 2 * W;

  logic block_q;
  logic [NUM_CH-1:0] hit;

  // One-tick suppression after a counter low-byte write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         block_q <= 1'b0;
    else if (cnt_lo_wr) block_q <= 1'b1;
    else if (step)      block_q <= 1'b0;
  end

  assign hit[CH_A] = wide ? (cnt_q == cmpa) : (cnt_q[W-1:0] == cmpa[W-1:0]);
  assign hit[CH_B] = (wide ? cnt_q[DW-1:W] : cnt_q[W-1:0]) == cmpb;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    logic flag_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           flag_r <= 1'b0;
      else if (step && !block_q && hit[c])  flag_r <= 1'b1;
      else if (flag_clr[c])                 flag_r <= 1'b0;
    end
    assign flags[c] = flag_r;
  end
endmodule

// File: rtl/dmt_top.sv
module dmt_top
  import dmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              count_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int DW = 2 * W;

  logic              wide;
  logic              cnt_ld, cnt_lo_wr, step;
  logic [DW-1:0]     cnt_ld_val, cnt_q, cmpa;
  logic [W-1:0]      cmpb;
  logic [NUM_CH-1:0] flag_clr, flags;

  dmt_bus #(.W(W)) u_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_q(cnt_q), .flags(flags), .rdata(rdata), .wide(wide),
    .cnt_ld(cnt_ld), .cnt_lo_wr(cnt_lo_wr), .cnt_ld_val(cnt_ld_val),
    .cmpa(cmpa), .cmpb(cmpb), .flag_clr(flag_clr)
  );

  dmt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(count_en), .wide(wide),
    .ld(cnt_ld), .ld_val(cnt_ld_val), .cnt_q(cnt_q), .step(step)
  );

  dmt_match #(.W(W)) u_match (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt_lo_wr(cnt_lo_wr), .wide(wide),
    .cnt_q(cnt_q), .cmpa(cmpa), .cmpb(cmpb), .flag_clr(flag_clr), .flags(flags)
  );

  assign irq_a = flags[CH_A];
  assign irq_b = flags[CH_B];
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
  import dmt_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              count_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic              wide,
  input logic [2*W-1:0]    cnt_q,
  input logic              irq_a
);
  localparam int DW = 2 * W;

  p_step8_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_en && !wr_en && !wide) |=>
      (cnt_q[W-1:0] == W'($past(cnt_q[W-1:0]) + 1'b1)) && $stable(cnt_q[DW-1:W]));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && count_en) && !wr_en) |=> $stable(cnt_q));

  p_step16_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_en && !wr_en && wide) |=> (cnt_q == DW'($past(cnt_q) + 1'b1)));

  p_wr_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_CNT_LO && !wide) |=> (cnt_q[W-1:0] == $past(wdata)));

  p_blocked_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_a && tick && count_en && !wr_en && $past(wr_en && addr == RA_CNT_LO)) |=> !irq_a);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a && !(wr_en && addr == RA_FLAGS && wdata[CH_A])) |=> irq_a);
endmodule

bind dmt_top dmt_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(count_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .wide(wide), .cnt_q(cnt_q), .irq_a(irq_a)
);

// File: tb/tb_dmt_top.sv
module tb_dmt_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, count_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic irq_a, irq_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  dmt_top #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(count_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops an expected byte for every read cycle
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rd_en) begin
      logic [W-1:0] e;
      string t;
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard empty: actual %0h expected none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", t, rdata, e);
        end
      end
    end
  end

  task automatic drive(input logic t, input logic en, input logic w, input logic r,
                       input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    tick = t; count_en = en; wr_en = w; rd_en = r; addr = a; wdata = d;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    drive(1'b0, 1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    drive(1'b0, 1'b0, 1'b0, 1'b1, a, '0);
  endtask

  task automatic ticks(input int n, input logic en);
    for (int i = 0; i < n; i++) drive(1'b1, en, 1'b0, 1'b0, 3'd0, '0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1 reset");

    // 8-bit mode
    wr(3'd3, 8'd10);             // compare A low
    wr(3'd5, 8'd20);             // compare B
    wr(3'd6, 8'h03);
    ticks(5, 1'b1);              // 0..4
    rd(3'd1, 8'd5, "R2 count");
    rd(3'd6, 8'h00, "R7 no early match");
    ticks(3, 1'b0);
    rd(3'd1, 8'd5, "R2 disabled hold");
    ticks(6, 1'b1);              // 5..10, 10 hits A
    rd(3'd6, 8'h01, "R7 match A 8-bit");
    idle(2);
    rd(3'd6, 8'h01, "R10 sticky");
    wr(3'd6, 8'h01);
    rd(3'd6, 8'h00, "R10 clear");
    ticks(9, 1'b1);              // 11..19
    rd(3'd6, 8'h00, "R8 before B");
    ticks(1, 1'b1);              // 20 hits B
    rd(3'd6, 8'h02, "R8 match B low byte");
    wr(3'd6, 8'h02);
    wr(3'd1, 8'd250);
    ticks(10, 1'b1);             // 250 blocked .. 3 -> 4
    rd(3'd1, 8'd4, "R2 wrap");
    rd(3'd2, 8'd0, "R2 high untouched");
    rd(3'd6, 8'h00, "R2 no match across wrap");

    // R9 blocking
    wr(3'd1, 8'd10);
    idle(2);
    ticks(1, 1'b1);              // 10 blocked
    rd(3'd6, 8'h00, "R9 blocked tick");
    rd(3'd1, 8'd11, "R9 count after blocked");
    wr(3'd1, 8'd9);
    ticks(2, 1'b1);              // 9 blocked, 10 hits
    rd(3'd6, 8'h01, "R9 only one tick blocked");
    wr(3'd6, 8'h01);

    // R4 write beats tick
    drive(1'b1, 1'b1, 1'b1, 1'b0, 3'd1, 8'd100);
    rd(3'd1, 8'd100, "R4 write priority");

    // 16-bit mode
    wr(3'd0, 8'h01);
    rd(3'd0, 8'h01, "R1 ctrl wide bit");
    wr(3'd2, 8'h12);             // staging only
    rd(3'd1, 8'd100, "R5 low unchanged");
    rd(3'd2, 8'h00, "R5 high not written");
    wr(3'd2, 8'h12);
    wr(3'd1, 8'h34);
    rd(3'd1, 8'h34, "R5 commit low");
    wr(3'd2, 8'h77);
    rd(3'd2, 8'h77, "R6 high read returns staging");
    rd(3'd1, 8'h34, "R6 low read");
    rd(3'd2, 8'h12, "R6 snapshot high");

    // R3 16-bit wrap
    wr(3'd2, 8'hFF);
    wr(3'd1, 8'hFE);
    ticks(3, 1'b1);              // FFFE blocked, FFFF, 0000 -> 0001
    rd(3'd1, 8'h01, "R3 wrap low");
    rd(3'd2, 8'h00, "R3 wrap high");
    rd(3'd6, 8'h00, "R3 no flags");

    // R7 16-bit compare A = 0x0105
    wr(3'd4, 8'h01);
    wr(3'd3, 8'h05);
    rd(3'd3, 8'h05, "R5 compare A low");
    rd(3'd4, 8'h01, "R5 compare A high");
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h04);
    ticks(3, 1'b1);              // 0004 blocked, 0005, 0006
    rd(3'd6, 8'h00, "R7 low-only match ignored in 16-bit");
    wr(3'd2, 8'h01);
    wr(3'd1, 8'h04);
    ticks(3, 1'b1);              // 0104 blocked, 0105 hits
    rd(3'd6, 8'h01, "R7 full 16-bit match");
    wr(3'd6, 8'h01);

    // R8 16-bit: B against high byte (20 = 0x14)
    wr(3'd2, 8'h13);
    wr(3'd1, 8'hFE);
    ticks(3, 1'b1);              // 13FE blocked, 13FF, 1400 hits
    rd(3'd6, 8'h02, "R8 match B high byte");
    wr(3'd6, 8'h02);
    rd(3'd6, 8'h00, "R10 clear B");

    idle(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule